// File: doc/BRIEF.md
# Lane control register bank

This block holds the per-lane configuration registers of one lane in an eight-lane signal-conditioning device and turns them into the lane's control outputs. Register access uses a byte-wide port. Writes are synchronous, with a single write strobe. Reads are combinational from the address. The byte layout inside the registers follows the decode that neighbouring logic expects.

The live detector status of the lane and of its partner lane arrive as inputs. The partner of lane N is N+1 for an even N and N-1 for an odd N. The shared pin-control enable and the two shared mux pins also arrive as plain inputs.

From the stored fields and these inputs, the block derives six registered outputs:
- the effective signal detect, which can be forced high or low;
- driver mute;
- driver power-down;
- equalizer power-down;
- the crosspoint source select;
- a sticky flag that reports a contradictory force setting.

The mute and power-down outputs follow loss of signal unless their override bits take over. A self-clearing bit restores every register to its default value.

Top module: `lane_ctrl_regs`

## Requirements
- R1: After reset, the registers read 0x00 at 0x00, 0x80 at 0x03, 0x90 at 0x04, 0x04 at 0x05, 0xC0 at 0x06, 0x50 at 0x08, 0x30 at 0x0A and 0x1A at 0x0B. Every other address from 0x02 to 0x19 reads 0x00. The outputs reset to sd_eff=0, drv_mute=1, drv_pd=1, eq_pd=1, src_adjacent=0 and cfg_err=0.
- R2: Writing a byte with bit 2 set to address 0x00 restores every register to its R1 default, and the other bits of that write are discarded. Bit 2 of address 0x00 always reads 0.
- R3: Address 0x01 reads {sd_local, sd_adjacent, 5'b0, 1'b1}, and writes to it have no effect.
- R4: Bits 7:4 of address 0x02 always read 0, while its bits 3:0 and all bits of the other addresses up to 0x19 are read/write. Addresses 0x1A to 0x1F read 0, and writes to them are ignored.
- R5: Bit 7 of 0x05 forces sd_eff to 1 and bit 6 forces it to 0. With neither bit set, sd_eff follows sd_local.
- R6: With both force bits of 0x05 set, sd_eff is 0 and cfg_err rises. cfg_err then stays set until reset or a register reset (R2).
- R7: With 0x06 bit 4 clear, drv_mute equals NOT sd_eff. With bit 4 set, drv_mute equals 0x06 bit 1.
- R8: With 0x06 bit 5 clear, drv_pd and eq_pd both equal NOT sd_eff. With bit 5 set, drv_pd equals 0x06 bit 3 and eq_pd equals 0x04 bit 3.
- R9: With pin_mode_en=0, src_adjacent equals 0x06 bit 0 (1 selects the partner lane's equalizer).
- R10: With pin_mode_en=1, src_adjacent equals mux_pins[g] XOR 0x07 bit 5. The group g is 0 for lanes 0, 1, 4 and 5 and 1 for lanes 2, 3, 6 and 7. The default lane is 2.
- R11: Every derived output changes at the first clock edge that samples the register write or the new sd_local value, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_addr | input | AW (5) | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sd_local | input | 1 | Raw signal detect of this lane |
| sd_adjacent | input | 1 | Raw signal detect of the partner lane |
| pin_mode_en | input | 1 | Shared enable: source select taken from a mux pin |
| mux_pins | input | NPIN (2) | Shared mux select pins, one per lane group |
| sd_eff | output | 1 | Effective signal detect after forcing |
| drv_mute | output | 1 | Driver mute |
| drv_pd | output | 1 | Driver power-down |
| eq_pd | output | 1 | Equalizer power-down |
| src_adjacent | output | 1 | 1: drive from the partner lane's equalizer |
| cfg_err | output | 1 | Sticky flag: both force bits were set together |

## Verification
The assertions assume that every input is synchronous to clk. In particular, the detector inputs must already be synchronized, and reg_addr, reg_wdata and reg_we must hold steady around the sampling edge. The stimulus meets this by changing every input on the falling edge, and it samples outputs on a later falling edge. The assertions also assume that only one access happens per cycle. The bench never drives the force bits into states it does not then check, and it never relies on read data during a write cycle.

// File: rtl/lane_regs_pkg.sv
// Package: shared constants and register-layout functions for the lane
// control register bank.
// Assumes 8-bit registers; the addresses and bit positions below are the ones
// that downstream decode depends on.
package lane_regs_pkg;

    localparam int REG_W = 8;

    // Addresses with behaviour
    localparam int A_GLOBAL   = 0;
    localparam int A_STATUS   = 1;
    localparam int A_MIXED    = 2;
    localparam int A_EQ_PWR   = 4;
    localparam int A_SD_FORCE = 5;
    localparam int A_DRV      = 6;
    localparam int A_PIN_INV  = 7;

    // Bit positions
    localparam int B_SOFT_RST = 2;
    localparam int B_FORCE_HI = 7;
    localparam int B_FORCE_LO = 6;
    localparam int B_PD_OVR   = 5;
    localparam int B_MUTE_OVR = 4;
    localparam int B_DRV_PD   = 3;
    localparam int B_MUTE     = 1;
    localparam int B_SRC      = 0;
    localparam int B_EQ_PD    = 3;
    localparam int B_PIN_INV  = 5;

    // Reset value of each register address
    function automatic logic [REG_W-1:0] reg_default(input int a);
        case (a)
            3:       return 8'h80;
            4:       return 8'h90;
            5:       return 8'h04;
            6:       return 8'hC0;
            8:       return 8'h50;
            10:      return 8'h30;
            11:      return 8'h1A;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that a write may change at each address
    function automatic logic [REG_W-1:0] wr_mask(input int a);
        case (a)
            A_GLOBAL: return 8'hFB;
            A_STATUS: return 8'h00;
            A_MIXED:  return 8'h0F;
            default:  return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/lane_reg_bank.sv
// Module: lane_reg_bank
// Stores the lane registers and applies byte writes through a per-address
// write mask. It also applies the self-clearing register reset. The
// next-state bank is exported so that the decoder can register its outputs
// on the same edge as the storage.
// Assumes: a single write per cycle, synchronous active-low reset.
module lane_reg_bank
    import lane_regs_pkg::*;
#(
    parameter int NREGS = 26,
    parameter int AW    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [NREGS-1:0][REG_W-1:0] bank_q,
    output logic [NREGS-1:0][REG_W-1:0] bank_d,
    output logic                        soft_rst
);

    // Detect a write that requests a register reset
    always_comb begin
        soft_rst = we && (addr == AW'(A_GLOBAL)) && wdata[B_SOFT_RST];
    end

    // Build the next-state bank from the register reset or the masked write
    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NREGS; i++) begin
            if (soft_rst) begin
                bank_d[i] = reg_default(i);
            end else if (we && (addr == AW'(i))) begin
                bank_d[i] = (wdata & wr_mask(i)) | (bank_q[i] & ~wr_mask(i));
            end
        end
    end

    // Storage flops with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                bank_q[i] <= reg_default(i);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    AST_SOFT_RST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_q[A_GLOBAL] == 8'h00 && bank_q[A_SD_FORCE] == 8'h04
                      && bank_q[A_DRV] == 8'hC0 && bank_q[A_EQ_PWR] == 8'h90)); // R2
    AST_STATUS_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q[A_STATUS] == 8'h00); // R3
    AST_RO_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q[A_MIXED][7:4] == 4'h0); // R4

endmodule

// File: rtl/lane_read_mux.sv
// Module: lane_read_mux
// Combinational read path. Address 0x01 is assembled from the live detector
// inputs. Addresses inside the bank return the stored byte, and addresses
// beyond it read 0.
// Assumes: the stored bank already holds zero in every read-only bit.
module lane_read_mux
    import lane_regs_pkg::*;
#(
    parameter int NREGS = 26,
    parameter int AW    = 5
) (
    input  logic [AW-1:0]               addr,
    input  logic [NREGS-1:0][REG_W-1:0] bank_q,
    input  logic                        sd_local,
    input  logic                        sd_adjacent,
    output logic [REG_W-1:0]            rdata
);

    // Select the read byte for the current address
    always_comb begin
        rdata = '0;
        if (addr == AW'(A_STATUS)) begin
            rdata = {sd_local, sd_adjacent, 5'b00000, 1'b1};
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (addr == AW'(i)) begin
                    rdata = bank_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/lane_ctrl_decode.sv
// Module: lane_ctrl_decode
// Turns the next-state register fields and the live inputs into the lane's
// registered control outputs: forced signal detect, mute, power-downs,
// crosspoint source and a sticky force-conflict flag.
// Assumes: bank_d is the value the bank takes at the same edge, and LANE_ID
// is in the range 0..7.
module lane_ctrl_decode
    import lane_regs_pkg::*;
#(
    parameter int NREGS   = 26,
    parameter int LANE_ID = 2,
    parameter int NPIN    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NREGS-1:0][REG_W-1:0] bank_d,
    input  logic                        soft_rst,
    input  logic                        sd_local,
    input  logic                        pin_mode_en,
    input  logic [NPIN-1:0]             mux_pins,
    output logic                        sd_eff,
    output logic                        drv_mute,
    output logic                        drv_pd,
    output logic                        eq_pd,
    output logic                        src_adjacent,
    output logic                        cfg_err
);

    localparam int PIN_GRP = (LANE_ID / 2) % NPIN;

    logic force_hi, force_lo;
    logic sd_eff_d, mute_d, drv_pd_d, eq_pd_d, src_d, err_d;

    // Resolve forcing: the forced-low bit wins over the forced-high bit
    always_comb begin
        force_hi = bank_d[A_SD_FORCE][B_FORCE_HI];
        force_lo = bank_d[A_SD_FORCE][B_FORCE_LO];
        if (force_lo)      sd_eff_d = 1'b0;
        else if (force_hi) sd_eff_d = 1'b1;
        else               sd_eff_d = sd_local;
    end

    // Mute and power-downs: automatic on loss of signal, or set by overrides
    always_comb begin
        mute_d = bank_d[A_DRV][B_MUTE_OVR] ? bank_d[A_DRV][B_MUTE] : !sd_eff_d;
        if (bank_d[A_DRV][B_PD_OVR]) begin
            drv_pd_d = bank_d[A_DRV][B_DRV_PD];
            eq_pd_d  = bank_d[A_EQ_PWR][B_EQ_PD];
        end else begin
            drv_pd_d = !sd_eff_d;
            eq_pd_d  = !sd_eff_d;
        end
    end

    // Crosspoint source: register bit, or the group's pin with optional invert
    always_comb begin
        if (pin_mode_en) src_d = mux_pins[PIN_GRP] ^ bank_d[A_PIN_INV][B_PIN_INV];
        else             src_d = bank_d[A_DRV][B_SRC];
    end

    // Sticky conflict flag, cleared only by reset or register reset
    always_comb begin
        if (soft_rst)                 err_d = 1'b0;
        else if (force_hi && force_lo) err_d = 1'b1;
        else                          err_d = cfg_err;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_eff       <= 1'b0;
            drv_mute     <= 1'b1;
            drv_pd       <= 1'b1;
            eq_pd        <= 1'b1;
            src_adjacent <= 1'b0;
            cfg_err      <= 1'b0;
        end else begin
            sd_eff       <= sd_eff_d;
            drv_mute     <= mute_d;
            drv_pd       <= drv_pd_d;
            eq_pd        <= eq_pd_d;
            src_adjacent <= src_d;
            cfg_err      <= err_d;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !soft_rst) |=> cfg_err); // R6
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !cfg_err); // R6

endmodule

// File: rtl/lane_ctrl_regs.sv
// Module: lane_ctrl_regs (top)
// Per-lane control register bank and decoder. It combines the storage, the
// read path and the control decoder. The relations between the stored
// fields and the registered outputs are checked here.
// Assumes: all inputs are synchronous to clk.
module lane_ctrl_regs
    import lane_regs_pkg::*;
#(
    parameter int LANE_ID = 2,
    parameter int NREGS   = 26,
    parameter int AW      = 5,
    parameter int NPIN    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sd_local,
    input  logic             sd_adjacent,
    input  logic             pin_mode_en,
    input  logic [NPIN-1:0]  mux_pins,
    output logic             sd_eff,
    output logic             drv_mute,
    output logic             drv_pd,
    output logic             eq_pd,
    output logic             src_adjacent,
    output logic             cfg_err
);

    logic [NREGS-1:0][REG_W-1:0] bank_q;
    logic [NREGS-1:0][REG_W-1:0] bank_d;
    logic                        soft_rst;

    lane_reg_bank #(.NREGS(NREGS), .AW(AW)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .bank_q   (bank_q),
        .bank_d   (bank_d),
        .soft_rst (soft_rst)
    );

    lane_read_mux #(.NREGS(NREGS), .AW(AW)) i_rmux (
        .addr        (reg_addr),
        .bank_q      (bank_q),
        .sd_local    (sd_local),
        .sd_adjacent (sd_adjacent),
        .rdata       (reg_rdata)
    );

    lane_ctrl_decode #(.NREGS(NREGS), .LANE_ID(LANE_ID), .NPIN(NPIN)) i_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_d       (bank_d),
        .soft_rst     (soft_rst),
        .sd_local     (sd_local),
        .pin_mode_en  (pin_mode_en),
        .mux_pins     (mux_pins),
        .sd_eff       (sd_eff),
        .drv_mute     (drv_mute),
        .drv_pd       (drv_pd),
        .eq_pd        (eq_pd),
        .src_adjacent (src_adjacent),
        .cfg_err      (cfg_err)
    );

    AST_AUTO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_q[A_DRV][B_MUTE_OVR] |-> (drv_mute == !sd_eff)); // R7
    AST_AUTO_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_q[A_DRV][B_PD_OVR] |-> (drv_pd == !sd_eff && eq_pd == !sd_eff)); // R8
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q[A_SD_FORCE][B_FORCE_HI] && !bank_q[A_SD_FORCE][B_FORCE_LO]) |-> sd_eff); // R5
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q[A_SD_FORCE][B_FORCE_LO] |-> !sd_eff); // R6

endmodule

// File: tb/test_lane_ctrl_regs.sv
module test_lane_ctrl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sd_local = 1'b0;
    logic       sd_adjacent = 1'b0;
    logic       pin_mode_en = 1'b0;
    logic [1:0] mux_pins = '0;
    logic       sd_eff, drv_mute, drv_pd, eq_pd, src_adjacent, cfg_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lane_ctrl_regs i_lane_ctrl_regs (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .sd_local (sd_local),
        .sd_adjacent (sd_adjacent), .pin_mode_en (pin_mode_en), .mux_pins (mux_pins),
        .sd_eff (sd_eff), .drv_mute (drv_mute), .drv_pd (drv_pd), .eq_pd (eq_pd),
        .src_adjacent (src_adjacent), .cfg_err (cfg_err)
    );

    // Source-select vectors for lane 2 (group pin is mux_pins[1]):
    // {pin_en, pin1, pin0, invert, reg_src, expected}
    localparam logic [5:0] SRC_VEC [8] = '{
        6'b000000, 6'b011111, 6'b110001, 6'b101010,
        6'b110100, 6'b100101, 6'b100010, 6'b010100
    };

    function automatic logic [7:0] exp_default(input int a);
        case (a)
            3: return 8'h80;  4: return 8'h90;  5: return 8'h04;  6: return 8'hC0;
            8: return 8'h50;  10: return 8'h30; 11: return 8'h1A;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic outs_chk(input string req, input logic [5:0] exp);
        chk(req, {2'b00, sd_eff, drv_mute, drv_pd, eq_pd, src_adjacent, cfg_err},
            {2'b00, exp});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: defaults and output reset state
        outs_chk("R1 outputs", 6'b011100);
        for (int a = 0; a < 26; a++) begin
            if (a == 1) rd_chk("R1 addr01", 5'(a), 8'h01);
            else        rd_chk("R1 default", 5'(a), exp_default(a));
        end

        // R11: sd change takes effect at the next edge only
        @(negedge clk);
        sd_local = 1'b1;
        #1;
        chk("R11 before edge", {7'b0, sd_eff}, 8'h00);
        @(negedge clk);
        outs_chk("R11 after edge / R7 R8 auto", 6'b100000);

        // R5: forcing
        @(negedge clk); sd_local = 1'b0;
        wr(5'h05, 8'h84);
        outs_chk("R5 force high", 6'b100000);
        @(negedge clk); sd_local = 1'b1;
        wr(5'h05, 8'h44);
        outs_chk("R5 force low", 6'b011100);
        // R6: both force bits
        wr(5'h05, 8'hC4);
        outs_chk("R6 both forced", 6'b011101);
        wr(5'h05, 8'h04);
        outs_chk("R6 sticky", 6'b100001);

        // R7: mute override
        wr(5'h06, 8'hD2);
        chk("R7 mute ovr on", {7'b0, drv_mute}, 8'h01);
        wr(5'h06, 8'hD0);
        @(negedge clk); sd_local = 1'b0;
        @(negedge clk);
        chk("R7 mute ovr off-bit", {7'b0, drv_mute}, 8'h00);
        chk("R8 auto pd on LOS", {6'b0, drv_pd, eq_pd}, 8'h03);

        // R8: power-down override
        wr(5'h06, 8'hE8);
        chk("R8 ovr drv1 eq0", {6'b0, drv_pd, eq_pd}, 8'h02);
        wr(5'h04, 8'h98);
        chk("R8 ovr eq1", {6'b0, drv_pd, eq_pd}, 8'h03);
        wr(5'h06, 8'hE0);
        chk("R8 ovr drv0", {6'b0, drv_pd, eq_pd}, 8'h01);
        wr(5'h04, 8'h90);

        // R9 R10: source select vectors
        foreach (SRC_VEC[i]) begin
            @(negedge clk);
            pin_mode_en = SRC_VEC[i][5];
            mux_pins    = SRC_VEC[i][4:3];
            wr(5'h07, {2'b00, SRC_VEC[i][2], 5'b0});
            wr(5'h06, {7'b1100000, SRC_VEC[i][1]});
            chk(SRC_VEC[i][5] ? "R10 pin source" : "R9 reg source",
                {7'b0, src_adjacent}, {7'b0, SRC_VEC[i][0]});
        end
        @(negedge clk); pin_mode_en = 1'b0; mux_pins = '0;

        // R3: status register
        sd_local = 1'b1; sd_adjacent = 1'b1;
        rd_chk("R3 status both", 5'h01, 8'hC1);
        @(negedge clk); sd_local = 1'b0;
        rd_chk("R3 status adj only", 5'h01, 8'h41);
        sd_adjacent = 1'b0;
        wr(5'h01, 8'hFE);
        rd_chk("R3 write ignored", 5'h01, 8'h01);

        // R4: masked and out-of-range addresses
        wr(5'h02, 8'hFF);
        rd_chk("R4 addr02 mask", 5'h02, 8'h0F);
        wr(5'h1C, 8'hAA);
        rd_chk("R4 beyond bank", 5'h1C, 8'h00);
        wr(5'h09, 8'h5A);
        rd_chk("R4 rw byte", 5'h09, 8'h5A);

        // R2: register reset, other bits of the write discarded
        wr(5'h00, 8'h5C);
        for (int a = 0; a < 26; a++) begin
            if (a != 1) rd_chk("R2 restored", 5'(a), exp_default(a));
        end
        chk("R6 cleared by R2", {7'b0, cfg_err}, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule